// File: doc/BRIEF.md
# Rename-Stage Immediate Offset Tracker

This block is the rename map of an out-of-order core, extended so that every architectural register is named by a pair: a physical register tag and a small signed offset. Moves of small constants, and additions or subtractions of small constants, are carried out in the map at rename time. They only rewrite the pair and send no micro-op to execution. A chain of such instructions therefore adds no latency and uses no adder port in the back end.

One decoded instruction arrives per cycle: an operation class, a destination, a source and an immediate. Physical tag 0 is reserved as a register that always reads zero. Constants are therefore stored as "tag 0 plus offset". If an instruction cannot be absorbed, the block requests a tag from the free list through `alloc_tag` / `alloc_req` and sends out a registered micro-op. That micro-op carries the source tag, the tracked source offset as an extra operand, and the immediate. A three-input add combines the base, the tracked offset and the new immediate. A combinational probe port reads any map entry.

Top module: `imm_rename_tracker`

## Requirements
- R1: After reset, architectural register r maps to physical tag r+1 with offset 0, and `uop_valid` is 0.
- R2: The move-immediate class (`in_op`=1) with an immediate in -1024..1023 maps the destination to tag 0, with the immediate as its offset. `alloc_req` stays 0 and no micro-op follows.
- R3: The add class (`in_op`=2, value = src + imm) and the subtract class (`in_op`=3, value = src - imm) fold the operation into the map when two conditions hold: the effective immediate (imm for add, -imm for subtract) is in -1024..1023, and the source offset plus that immediate is also in -1024..1023. The destination then takes the source tag and the new offset, and no micro-op is issued.
- R4: An add or subtract whose new offset would leave -1024..1023 is issued one cycle later as kind 1 (three-input add). It carries the source tag, the source offset and the effective immediate, and writes a freshly allocated tag. The destination then maps to that tag with offset 0.
- R5: An effective immediate outside -1024..1023 is issued rather than absorbed. For a move it is issued as kind 0 with the immediate. For an add or subtract it is issued as kind 1.
- R6: The generic operation class (`in_op`=5, dst = f(src)) is always issued as kind 2. It carries the source tag and offset, and `uop_off_used` is 1 exactly when that offset is nonzero. The destination maps to the fresh tag with offset 0.
- R7: `alloc_req` is 1 in the same cycle as a valid instruction that will be issued, and only then. The micro-op's destination tag is the `alloc_tag` presented in that cycle.
- R8: The zeroing class (`in_op`=4) maps the destination to tag 0 with offset 0, and no micro-op is issued. An add of a small immediate that follows is then absorbed, giving tag 0 plus the immediate. An add on a register whose base is unknown keeps that base, and consumers receive the offset as an operand.
- R9: A no-operation (`in_op`=0) or a cycle with `in_valid` low changes no map entry and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Class: 0 nop, 1 move-imm, 2 add-imm, 3 sub-imm, 4 zero, 5 generic |
| in_dst | input | 4 | Destination architectural register |
| in_src | input | 4 | Source architectural register |
| in_imm | input | 16 | Signed immediate |
| alloc_tag | input | 7 | Free physical tag offered by the free list |
| alloc_req | output | 1 | Offered tag is consumed this cycle |
| uop_valid | output | 1 | Issue-needed: a micro-op is presented |
| uop_kind | output | 2 | 0 move-imm, 1 three-input add, 2 generic |
| uop_dst_tag | output | 7 | Destination physical tag |
| uop_src_tag | output | 7 | Source physical tag |
| uop_src_off | output | 11 | Tracked source offset (extra operand) |
| uop_off_used | output | 1 | Source offset is nonzero |
| uop_imm | output | 17 | Signed effective immediate |
| probe_reg | input | 4 | Map entry to read |
| probe_tag | output | 7 | Physical tag of probed entry |
| probe_off | output | 11 | Offset of probed entry |

## Verification
The bench gives each physical tag a value and executes every issued micro-op itself. It then checks that, for every architectural register, the probed tag's value plus the probed offset equals the register's architectural value. Folding chains on both constant and unknown bases show that offsets accumulate against the correct base. Immediates at exactly -1024 and +1023, and sums one step past either limit, separate absorption from issue. Large immediates, subtraction of -1024 and generic operations on zero and nonzero offsets check the form of the issued micro-op: its kind, its tags and its extra operand.

// File: rtl/imr_pkg.sv
package imr_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MOVI = 3'd1,
    OP_ADDI = 3'd2,
    OP_SUBI = 3'd3,
    OP_ZERO = 3'd4,
    OP_ALU  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    K_MOVI = 2'd0,
    K_ADD3 = 2'd1,
    K_ALU  = 2'd2
  } kind_e;

endpackage

// File: rtl/imr_map.sv
module imr_map #(
  parameter int NREG   = 16,
  parameter int PTAG_W = 7,
  parameter int OFF_W  = 11,
  localparam int AIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AIDX_W-1:0] wr_idx,
  input  logic [PTAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [AIDX_W-1:0] rd_idx,
  output logic [PTAG_W-1:0] rd_tag,
  output logic [OFF_W-1:0]  rd_off,
  input  logic [AIDX_W-1:0] pr_idx,
  output logic [PTAG_W-1:0] pr_tag,
  output logic [OFF_W-1:0]  pr_off
);

  logic [PTAG_W-1:0] ent_tag   [NREG];
  logic [OFF_W-1:0]  ent_off   [NREG];
  logic [PTAG_W-1:0] ent_tag_d [NREG];
  logic [OFF_W-1:0]  ent_off_d [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == AIDX_W'(i));

    always_comb begin
      ent_tag_d[i] = ent_tag[i];
      ent_off_d[i] = ent_off[i];
      if (hit) begin
        ent_tag_d[i] = wr_tag;
        ent_off_d[i] = wr_off;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_tag[i] <= PTAG_W'(i + 1);
        ent_off[i] <= '0;
      end else if (hit) begin
        ent_tag[i] <= ent_tag_d[i];
        ent_off[i] <= ent_off_d[i];
      end
    end
  end

  assign rd_tag = ent_tag[rd_idx];
  assign rd_off = ent_off[rd_idx];
  assign pr_tag = ent_tag[pr_idx];
  assign pr_off = ent_off[pr_idx];

  // R1
  reset_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ent_off[0] == '0));

endmodule

// File: rtl/imr_fold.sv
module imr_fold
  import imr_pkg::*;
#(
  parameter int OFF_W = 11,
  parameter int IMM_W = 16,
  localparam int EW = IMM_W + 1
) (
  input  logic [2:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [OFF_W-1:0] src_off,
  output logic             writes,
  output logic             absorb,
  output logic             zero_base,
  output logic [OFF_W-1:0] new_off,
  output logic [EW-1:0]    eff_imm,
  output logic [1:0]       kind
);

  logic [EW-1:0]    imm_x;
  logic             imm_ok;
  logic [OFF_W:0]   sum;
  logic             sum_ovf;
  logic [EW-OFF_W:0] top_bits;
  op_e              opc;

  assign opc      = op_e'(op);
  assign imm_x    = {imm[IMM_W-1], imm};
  assign eff_imm  = (opc == OP_SUBI) ? (~imm_x + EW'(1)) : imm_x;
  assign top_bits = eff_imm[EW-1:OFF_W-1];
  assign imm_ok   = (&top_bits) | ~(|top_bits);
  assign sum      = {src_off[OFF_W-1], src_off} + {eff_imm[OFF_W-1], eff_imm[OFF_W-1:0]};
  assign sum_ovf  = sum[OFF_W] ^ sum[OFF_W-1];

  always_comb begin
    writes    = 1'b0;
    absorb    = 1'b0;
    zero_base = 1'b0;
    new_off   = '0;
    kind      = K_ALU;
    unique case (opc)
      OP_MOVI: begin
        writes    = 1'b1;
        absorb    = imm_ok;
        zero_base = 1'b1;
        new_off   = imm[OFF_W-1:0];
        kind      = K_MOVI;
      end
      OP_ADDI, OP_SUBI: begin
        writes  = 1'b1;
        absorb  = imm_ok && !sum_ovf;
        new_off = sum[OFF_W-1:0];
        kind    = K_ADD3;
      end
      OP_ZERO: begin
        writes    = 1'b1;
        absorb    = 1'b1;
        zero_base = 1'b1;
      end
      OP_ALU: begin
        writes = 1'b1;
        kind   = K_ALU;
      end
      default: ;
    endcase
  end

  // R3
  always_comb begin
    if (absorb && (opc == OP_ADDI || opc == OP_SUBI)) begin
      fold_sum_chk: assert (int'($signed(new_off)) ==
                            int'($signed(src_off)) + int'($signed(eff_imm)));
    end
  end

endmodule

// File: rtl/imr_uop_reg.sv
module imr_uop_reg #(
  parameter int PTAG_W = 7,
  parameter int OFF_W  = 11,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [1:0]        kind_i,
  input  logic [PTAG_W-1:0] dst_i,
  input  logic [PTAG_W-1:0] src_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [IMM_W:0]    imm_i,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic [PTAG_W-1:0] dst_o,
  output logic [PTAG_W-1:0] src_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              off_used_o,
  output logic [IMM_W:0]    imm_o
);

  logic used_d;
  assign used_d = |off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_o     <= '0;
      dst_o      <= '0;
      src_o      <= '0;
      off_o      <= '0;
      off_used_o <= 1'b0;
      imm_o      <= '0;
    end else if (issue) begin
      kind_o     <= kind_i;
      dst_o      <= dst_i;
      src_o      <= src_i;
      off_o      <= off_i;
      off_used_o <= used_d;
      imm_o      <= imm_i;
    end
  end

endmodule

// File: rtl/imm_rename_tracker.sv
module imm_rename_tracker
  import imr_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int PTAG_W = 7,
  parameter int OFF_W  = 11,
  parameter int IMM_W  = 16,
  localparam int AIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [AIDX_W-1:0] in_dst,
  input  logic [AIDX_W-1:0] in_src,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [PTAG_W-1:0] alloc_tag,
  output logic              alloc_req,
  output logic              uop_valid,
  output logic [1:0]        uop_kind,
  output logic [PTAG_W-1:0] uop_dst_tag,
  output logic [PTAG_W-1:0] uop_src_tag,
  output logic [OFF_W-1:0]  uop_src_off,
  output logic              uop_off_used,
  output logic [IMM_W:0]    uop_imm,
  input  logic [AIDX_W-1:0] probe_reg,
  output logic [PTAG_W-1:0] probe_tag,
  output logic [OFF_W-1:0]  probe_off
);

  logic [PTAG_W-1:0] src_tag;
  logic [OFF_W-1:0]  src_off;
  logic              writes, absorb, zero_base;
  logic [OFF_W-1:0]  new_off;
  logic [IMM_W:0]    eff_imm;
  logic [1:0]        kind;
  logic              wr_en, issue;
  logic [PTAG_W-1:0] wr_tag;
  logic [OFF_W-1:0]  wr_off;
  logic [PTAG_W-1:0] u_src_tag;
  logic [OFF_W-1:0]  u_src_off;
  logic [IMM_W:0]    u_imm;

  imr_fold #(.OFF_W(OFF_W), .IMM_W(IMM_W)) u_fold (
    .op(in_op), .imm(in_imm), .src_off(src_off),
    .writes(writes), .absorb(absorb), .zero_base(zero_base),
    .new_off(new_off), .eff_imm(eff_imm), .kind(kind)
  );

  assign wr_en     = in_valid && writes;
  assign issue     = wr_en && !absorb;
  assign alloc_req = issue;

  always_comb begin
    if (absorb) begin
      wr_tag = zero_base ? '0 : src_tag;
      wr_off = new_off;
    end else begin
      wr_tag = alloc_tag;
      wr_off = '0;
    end
  end

  always_comb begin
    u_src_tag = src_tag;
    u_src_off = src_off;
    u_imm     = eff_imm;
    if (kind == K_MOVI) begin
      u_src_tag = '0;
      u_src_off = '0;
    end
    if (kind == K_ALU) u_imm = '0;
  end

  imr_map #(.NREG(NREG), .PTAG_W(PTAG_W), .OFF_W(OFF_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(in_dst), .wr_tag(wr_tag), .wr_off(wr_off),
    .rd_idx(in_src), .rd_tag(src_tag), .rd_off(src_off),
    .pr_idx(probe_reg), .pr_tag(probe_tag), .pr_off(probe_off)
  );

  imr_uop_reg #(.PTAG_W(PTAG_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_uop (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .kind_i(kind), .dst_i(alloc_tag), .src_i(u_src_tag),
    .off_i(u_src_off), .imm_i(u_imm),
    .valid_o(uop_valid), .kind_o(uop_kind), .dst_o(uop_dst_tag),
    .src_o(uop_src_tag), .off_o(uop_src_off), .off_used_o(uop_off_used),
    .imm_o(uop_imm)
  );

  // R2
  movi_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd1 && in_imm[IMM_W-1:OFF_W-1] == '0) |=> !uop_valid);

  // R7
  alloc_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (uop_valid && uop_dst_tag == $past(alloc_tag)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !uop_valid);

  // R6
  alu_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd5) |=> (uop_valid && uop_kind == 2'd2));

endmodule

// File: tb/imm_rename_tracker_bench.sv
module imm_rename_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PTAG_W = 7;
  localparam int OFF_W = 11;
  localparam int IMM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [3:0] in_dst = '0, in_src = '0;
  logic [IMM_W-1:0] in_imm = '0;
  logic [PTAG_W-1:0] alloc_tag;
  logic alloc_req, uop_valid, uop_off_used;
  logic [1:0] uop_kind;
  logic [PTAG_W-1:0] uop_dst_tag, uop_src_tag, probe_tag;
  logic [OFF_W-1:0] uop_src_off, probe_off;
  logic [IMM_W:0] uop_imm;
  logic [3:0] probe_reg = '0;

  int checks = 0, errors = 0;
  int phys [128];
  int arch [16];
  int next_tag = 17;

  assign alloc_tag = PTAG_W'(next_tag);

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_rename_tracker u_imm_rename_tracker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .alloc_tag(alloc_tag), .alloc_req(alloc_req),
    .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_dst_tag(uop_dst_tag),
    .uop_src_tag(uop_src_tag), .uop_src_off(uop_src_off),
    .uop_off_used(uop_off_used), .uop_imm(uop_imm),
    .probe_reg(probe_reg), .probe_tag(probe_tag), .probe_off(probe_off)
  );

  function automatic int fgen(int x);
    return x * 3 + 7;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe_chk(int r, int etag, int eoff, string req);
    probe_reg = 4'(r);
    #1;
    chk(int'(probe_tag) == etag, req, int'(probe_tag), etag);
    chk(int'($signed(probe_off)) == eoff, req, int'($signed(probe_off)), eoff);
  endtask

  task automatic check_all(string req);
    bit ok = 1;
    int bad = 0, got = 0;
    for (int r = 0; r < 16; r++) begin
      probe_reg = 4'(r);
      #1;
      got = phys[probe_tag] + int'($signed(probe_off));
      if (got != arch[r] && ok) begin
        ok = 0;
        bad = got;
        $display("  map mismatch at r%0d", r);
      end
    end
    chk(ok, req, bad, 0);
  endtask

  task automatic do_instr(bit v, int op, int dst, int src, int imm, bit exp_issue, string req);
    int cap;
    int srcv;
    @(negedge clk);
    in_valid = v; in_op = 3'(op); in_dst = 4'(dst); in_src = 4'(src);
    in_imm = IMM_W'(imm);
    #1;
    chk(alloc_req == exp_issue, {req, "/R7 alloc"}, int'(alloc_req), int'(exp_issue));
    cap = next_tag;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(uop_valid == exp_issue, {req, " issue"}, int'(uop_valid), int'(exp_issue));
    if (uop_valid) begin
      chk(int'(uop_dst_tag) == cap, {req, "/R7 dst tag"}, int'(uop_dst_tag), cap);
      srcv = phys[uop_src_tag] + int'($signed(uop_src_off));
      case (uop_kind)
        2'd0: phys[uop_dst_tag] = int'($signed(uop_imm));
        2'd1: phys[uop_dst_tag] = srcv + int'($signed(uop_imm));
        default: phys[uop_dst_tag] = fgen(srcv);
      endcase
      next_tag++;
    end
    if (v) begin
      case (op)
        1: arch[dst] = imm;
        2: arch[dst] = arch[src] + imm;
        3: arch[dst] = arch[src] - imm;
        4: arch[dst] = 0;
        5: arch[dst] = fgen(arch[src]);
        default: ;
      endcase
    end
    check_all({req, " map"});
  endtask

  task automatic t_reset();
    for (int r = 0; r < 16; r++) probe_chk(r, r + 1, 0, "R1");
    chk(uop_valid == 1'b0, "R1 valid", int'(uop_valid), 0);
  endtask

  task automatic t_movi();
    do_instr(1, 1, 2, 0, 5, 0, "R2");
    probe_chk(2, 0, 5, "R2");
    do_instr(1, 1, 3, 0, -1024, 0, "R2");
    probe_chk(3, 0, -1024, "R2");
    do_instr(1, 1, 4, 0, 1023, 0, "R2");
    probe_chk(4, 0, 1023, "R2");
  endtask

  task automatic t_fold();
    do_instr(1, 2, 5, 5, 7, 0, "R3");
    probe_chk(5, 6, 7, "R3");
    do_instr(1, 2, 6, 5, 100, 0, "R3");
    probe_chk(6, 6, 107, "R3");
    do_instr(1, 3, 6, 6, 200, 0, "R3");
    probe_chk(6, 6, -93, "R3");
    do_instr(1, 2, 7, 3, 1023, 0, "R3");
    probe_chk(7, 0, -1, "R3");
    do_instr(1, 2, 10, 10, -1024, 0, "R3");
    probe_chk(10, 11, -1024, "R3");
  endtask

  task automatic t_ovf();
    int t;
    t = next_tag;
    do_instr(1, 2, 4, 4, 1, 1, "R4");
    chk(uop_kind == 2'd1, "R4 kind", int'(uop_kind), 1);
    chk(uop_src_tag == 0, "R4 src tag", int'(uop_src_tag), 0);
    chk(int'($signed(uop_src_off)) == 1023, "R4 src off", int'($signed(uop_src_off)), 1023);
    chk(int'($signed(uop_imm)) == 1, "R4 imm", int'($signed(uop_imm)), 1);
    probe_chk(4, t, 0, "R4");
    do_instr(1, 3, 3, 3, 1, 1, "R4");
    chk(int'($signed(uop_imm)) == -1, "R4 sub imm", int'($signed(uop_imm)), -1);
    chk(int'($signed(uop_src_off)) == -1024, "R4 sub off", int'($signed(uop_src_off)), -1024);
  endtask

  task automatic t_bigimm();
    int t;
    t = next_tag;
    do_instr(1, 1, 8, 0, 2000, 1, "R5");
    chk(uop_kind == 2'd0, "R5 kind", int'(uop_kind), 0);
    chk(int'($signed(uop_imm)) == 2000, "R5 imm", int'($signed(uop_imm)), 2000);
    probe_chk(8, t, 0, "R5");
    do_instr(1, 3, 9, 9, -1024, 1, "R5");
    chk(uop_kind == 2'd1, "R5 sub kind", int'(uop_kind), 1);
    chk(int'($signed(uop_imm)) == 1024, "R5 sub imm", int'($signed(uop_imm)), 1024);
  endtask

  task automatic t_alu();
    do_instr(1, 5, 11, 2, 0, 1, "R6");
    chk(uop_kind == 2'd2, "R6 kind", int'(uop_kind), 2);
    chk(uop_off_used == 1'b1, "R6 used", int'(uop_off_used), 1);
    chk(int'($signed(uop_src_off)) == 5, "R6 off", int'($signed(uop_src_off)), 5);
    do_instr(1, 5, 12, 12, 0, 1, "R6");
    chk(uop_off_used == 1'b0, "R6 unused", int'(uop_off_used), 0);
    chk(int'(uop_src_tag) == 13, "R6 src tag", int'(uop_src_tag), 13);
  endtask

  task automatic t_zero();
    do_instr(1, 4, 1, 0, 0, 0, "R8");
    probe_chk(1, 0, 0, "R8");
    do_instr(1, 2, 1, 1, 1, 0, "R8");
    probe_chk(1, 0, 1, "R8");
    do_instr(1, 2, 13, 13, 1, 0, "R8");
    probe_chk(13, 14, 1, "R8");
    do_instr(1, 5, 14, 13, 0, 1, "R8");
    chk(uop_off_used == 1'b1, "R8 used", int'(uop_off_used), 1);
    chk(int'(uop_src_tag) == 14, "R8 base", int'(uop_src_tag), 14);
  endtask

  task automatic t_idle();
    do_instr(1, 0, 2, 2, 99, 0, "R9");
    probe_chk(2, 0, 5, "R9");
    do_instr(0, 1, 2, 0, 77, 0, "R9");
    probe_chk(2, 0, 5, "R9");
  endtask

  initial begin
    phys[0] = 0;
    for (int i = 1; i < 128; i++) phys[i] = 1000 * i + 17;
    for (int r = 0; r < 16; r++) arch[r] = phys[r + 1];
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_movi();
    t_fold();
    t_ovf();
    t_bigimm();
    t_alu();
    t_zero();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule